// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned words and a carry-in without a ripple chain. The word is cut into groups of `GW` bits. Each group forms a generate term (both operand bits set) and a propagate term (either operand bit set) for every bit position. It then computes every internal carry directly from those terms as one flat sum of products. Each group also reports a group generate and a group propagate. A second lookahead stage applies the same carry equations to these group terms. That stage produces the carry entering each group and the final carry-out, so no carry ever walks from group to group.

The sum, carry-out and word-level generate and propagate are captured in output registers. Results therefore appear on the clock edge after the operands are presented. The registers clear on a synchronous, active-high reset. With `GROUPS=1`, the block acts as a single 4-bit fast adder. With the default `GROUPS=4`, it is a 16-bit adder.

Top module: `cla_adder`

## Requirements
- R1: While `rst` is high at a rising edge, all registered outputs become zero on that edge.
- R2: One edge after the operands are applied with `rst` low, `sum_q` equals the low `GW*GROUPS` bits of `op_a + op_b + carry_in`.
- R3: One edge after the operands are applied, `carry_out_q` equals bit `GW*GROUPS` of `op_a + op_b + carry_in`. The carry entering each group, taken from the second lookahead stage, equals the carry leaving the group below it.
- R4: `grp_gen_q` is 1 exactly when `op_a + op_b` without carry-in overflows the word, and a set `grp_gen_q` always comes with a set `carry_out_q`.
- R5: `grp_prop_q` is 1 exactly when every bit position has `op_a` or `op_b` set (inclusive OR in every position).
- R6: The registered carry-out always equals `grp_gen_q OR (grp_prop_q AND carry_in)`, where `carry_in` is the value registered with the same operands.
- R7: A carry-in of 1 with complementary operands (`op_a XOR op_b` all ones) travels across every bit and every group, giving a zero sum and a carry-out of 1.
- R8: With `GROUPS=1`, `GW=4`, the block gives the results of R2 to R5 for all 512 combinations of two 4-bit operands and a carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | GW*GROUPS | First operand |
| op_b | input | GW*GROUPS | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_q | output | GW*GROUPS | Registered sum |
| carry_out_q | output | 1 | Registered carry out of the top bit |
| grp_gen_q | output | 1 | Registered word-level generate |
| grp_prop_q | output | 1 | Registered word-level propagate |

## Verification
The 4-bit configuration is driven through all operand and carry-in combinations. This exposes any missing or misplaced product term in a single group's carries, and any mix-up between the OR-form propagate and the XOR used for the sum. The 16-bit configuration is driven with random words, which exercise generate and propagate patterns at the group level. Directed words are added on top of the random ones. Complementary operands with a carry-in of 1 make the carry cross all four groups, and each set top bit generates on its own, so the second lookahead stage is told apart from the first. Words where every position has at least one set bit but no position generates separate the group propagate from the group generate.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Generate/propagate pair summarising one group of bits
  typedef struct packed {
    logic gen;
    logic prop;
  } cla_grp_t;
endpackage

// File: rtl/cla_carry_net.sv
// Flat carry lookahead network: every carry is an OR of AND terms, no chain.
module cla_carry_net #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N-1:0] cout_o,   // cout_o[i] is the carry out of position i
  output logic         grp_gen,
  output logic         grp_prop
);
  // Carry out of position i: any lower generate whose propagates reach i,
  // or the carry-in propagated through positions 0..i.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic term;
      logic acc;
      acc = 1'b0;
      for (int j = 0; j <= i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k <= i; k++) term = term & prop_i[k];
        acc = acc | term;
      end
      term = cin;
      for (int k = 0; k <= i; k++) term = term & prop_i[k];
      cout_o[i] = acc | term;
    end
  end

  // Group generate: same products as the top carry, without the carry-in term
  always_comb begin
    logic term;
    grp_gen = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < N; k++) term = term & prop_i[k];
      grp_gen = grp_gen | term;
    end
  end

  assign grp_prop = &prop_i;
endmodule

// File: rtl/cla_nibble.sv
// One group: per-bit generate/propagate, flat carries, sum and group terms.
module cla_nibble
  import cla_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          cout,
  output cla_grp_t      grp
);
  logic [GW-1:0] bit_gen, bit_prop, bit_cout;
  logic [GW:0]   carry_vec;

  assign bit_gen  = a & b;
  assign bit_prop = a | b;

  cla_carry_net #(.N(GW)) u_net (
    .gen_i   (bit_gen),
    .prop_i  (bit_prop),
    .cin     (cin),
    .cout_o  (bit_cout),
    .grp_gen (grp.gen),
    .grp_prop(grp.prop)
  );

  assign carry_vec = {bit_cout, cin};
  // OR-form propagate is unusable here; the sum needs the exclusive OR
  assign sum  = a ^ b ^ carry_vec[GW-1:0];
  assign cout = carry_vec[GW];
endmodule

// File: rtl/cla_adder.sv
// Multi-group lookahead adder with a second lookahead level and output registers.
module cla_adder
  import cla_pkg::*;
#(
  parameter int GW     = 4,
  parameter int GROUPS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GW*GROUPS-1:0] op_a,
  input  logic [GW*GROUPS-1:0] op_b,
  input  logic                 carry_in,
  output logic [GW*GROUPS-1:0] sum_q,
  output logic                 carry_out_q,
  output logic                 grp_gen_q,
  output logic                 grp_prop_q
);
  localparam int W = GW * GROUPS;

  cla_grp_t          nib_grp [GROUPS];
  logic [GROUPS-1:0] nib_gen, nib_prop, nib_cout, lvl_cout;
  logic [GROUPS:0]   grp_cin;
  logic [W-1:0]      sum_c;
  logic              lvl_gen, lvl_prop;

  assign grp_cin = {lvl_cout, carry_in};

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    cla_nibble #(.GW(GW)) u_nib (
      .a   (op_a[g*GW +: GW]),
      .b   (op_b[g*GW +: GW]),
      .cin (grp_cin[g]),
      .sum (sum_c[g*GW +: GW]),
      .cout(nib_cout[g]),
      .grp (nib_grp[g])
    );
    assign nib_gen[g]  = nib_grp[g].gen;
    assign nib_prop[g] = nib_grp[g].prop;
  end

  // Second level: same equations applied to the group terms
  cla_carry_net #(.N(GROUPS)) u_lvl2 (
    .gen_i   (nib_gen),
    .prop_i  (nib_prop),
    .cin     (carry_in),
    .cout_o  (lvl_cout),
    .grp_gen (lvl_gen),
    .grp_prop(lvl_prop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q       <= '0;
      carry_out_q <= 1'b0;
      grp_gen_q   <= 1'b0;
      grp_prop_q  <= 1'b0;
    end else begin
      sum_q       <= sum_c;
      carry_out_q <= grp_cin[GROUPS];
      grp_gen_q   <= lvl_gen;
      grp_prop_q  <= lvl_prop;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !carry_out_q && !grp_gen_q && !grp_prop_q));
  // R3: second-level carries agree with each group's own carry out
  a_r3_group_carry_agree: assert property (@(posedge clk) disable iff (rst)
    nib_cout == lvl_cout);
  // R4
  a_r4_gen_forces_carry: assert property (@(posedge clk) disable iff (rst)
    grp_gen_q |-> carry_out_q);
  // R6
  a_r6_carry_merge: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (carry_out_q == (grp_gen_q | (grp_prop_q & $past(carry_in)))));
  // R7
  a_r7_full_chain: assert property (@(posedge clk) disable iff (rst)
    ((op_a ^ op_b) == {W{1'b1}} && carry_in) |=> (sum_q == '0 && carry_out_q));
endmodule

// File: tb/test_cla_adder.sv
module test_cla_adder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0;
  logic        c16 = 1'b0;
  logic [15:0] s16;
  logic        co16, gg16, gp16;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        c4 = 1'b0;
  logic [3:0]  s4;
  logic        co4, gg4, gp4;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  cla_adder #(.GW(4), .GROUPS(4)) i_cla_adder (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .carry_in(c16),
    .sum_q(s16), .carry_out_q(co16), .grp_gen_q(gg16), .grp_prop_q(gp16));

  cla_adder #(.GW(4), .GROUPS(1)) i_cla_adder_nib (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .carry_in(c4),
    .sum_q(s4), .carry_out_q(co4), .grp_gen_q(gg4), .grp_prop_q(gp4));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: integer arithmetic on the applied operands
  task automatic check16(input string tag, input logic [15:0] a, input logic [15:0] b, input logic c);
    int full;
    int nocin;
    full  = int'(a) + int'(b) + int'(c);
    nocin = int'(a) + int'(b);
    chk({"R2 sum16 ", tag}, 32'(s16), full & 16'hFFFF);
    chk({"R3 cout16 ", tag}, 32'(co16), (full >> 16) & 1);
    chk({"R4 gen16 ", tag}, 32'(gg16), (nocin >> 16) & 1);
    chk({"R5 prop16 ", tag}, 32'(gp16), 32'(&(a | b)));
  endtask

  task automatic check4(input logic [3:0] a, input logic [3:0] b, input logic c);
    int full;
    int nocin;
    full  = int'(a) + int'(b) + int'(c);
    nocin = int'(a) + int'(b);
    chk("R8 sum4", 32'(s4), full & 15);
    chk("R8 cout4", 32'(co4), (full >> 4) & 1);
    chk("R8 gen4", 32'(gg4), (nocin >> 4) & 1);
    chk("R8 prop4", 32'(gp4), 32'(&(a | b)));
  endtask

  // Drive at the falling edge, capture at the rising edge, sample at the next falling edge
  task automatic step16(input string tag, input logic [15:0] a, input logic [15:0] b, input logic c);
    a16 = a; b16 = b; c16 = c;
    @(posedge clk); @(negedge clk);
    check16(tag, a, b, c);
  endtask

  initial begin
    a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1;
    a4 = 4'hF; b4 = 4'hF; c4 = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset sum16", 32'(s16), 0);
    chk("R1 reset flags16", {29'd0, co16, gg16, gp16}, 0);
    chk("R1 reset flags4", {24'd0, s4, 1'b0, co4, gg4, gp4}, 0);
    rst = 1'b0;

    // Directed corner words for the 16-bit unit
    step16("zero", 16'h0000, 16'h0000, 1'b0);
    step16("R7 chain", 16'hAAAA, 16'h5555, 1'b1);
    chk("R7 chain sum zero", 32'(s16), 0);
    step16("R7 ones", 16'hFFFF, 16'h0000, 1'b1);
    step16("prop no gen", 16'hF0F0, 16'h0F0F, 1'b0);
    step16("top gen", 16'h8000, 16'h8000, 1'b0);
    step16("all gen", 16'hFFFF, 16'hFFFF, 1'b1);
    step16("group edge", 16'h0FFF, 16'h0001, 1'b0);

    // Exhaustive 4-bit unit alongside random 16-bit words
    for (int v = 0; v < 512; v++) begin
      logic [15:0] ra, rb;
      logic        rc;
      ra = 16'($urandom); rb = 16'($urandom); rc = 1'($urandom);
      a4 = 4'(v); b4 = 4'(v >> 4); c4 = 1'(v >> 8);
      a16 = ra; b16 = rb; c16 = rc;
      @(posedge clk); @(negedge clk);
      check4(4'(v), 4'(v >> 4), 1'(v >> 8));
      check16("random", ra, rb, rc);
    end
    for (int v = 0; v < 1500; v++) begin
      logic [15:0] ra;
      ra = 16'($urandom);
      step16("random", ra, 16'($urandom), 1'($urandom));
      step16("R7 complement", ra, ~ra, 1'b1);
    end

    // Reset in the middle of traffic
    a16 = 16'h1234; b16 = 16'hFEDC; c16 = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 midrun sum16", 32'(s16), 0);
    chk("R1 midrun flags16", {29'd0, co16, gg16, gp16}, 0);
    rst = 1'b0;
    step16("after reset", 16'h1234, 16'hFEDC, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule